// File: doc/BRIEF.md
# AHB-Lite Register Access Bridge

This block sits between an AHB-Lite manager and a register file. It watches the bus for a valid address phase, latches the address, the transfer direction and the byte lanes implied by the transfer size, and then spends the data phase driving a single read or write strobe toward the register file. Write data comes straight from the bus data lines during the data phase. Read data, completion and failure come back from the register file and are turned into the bus read data, ready and response outputs.

The bus and the register file share one clock and one active-low asynchronous reset. A transfer that is misaligned for its size, or wider than the data bus, never reaches the register file and is answered with the two-cycle error response. The register file may stretch an access by holding its ready low. It may also reject an access by raising its error flag together with ready, which the bridge turns into the two-cycle error response. Burst type, protection and lock attributes are accepted and ignored.

Top module: `ahb_reg_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hReadyOut is 1, hResp is 0 (OKAY) and neither regWrEn nor regRdEn is asserted.
- R2: A cycle with hSel low, or with hTrans equal to IDLE (2'b00) or BUSY (2'b01), starts no access: in the following cycle no strobe is asserted, hReadyOut is 1 and hResp is 0.
- R3: A write address phase (hSel high, hTrans NONSEQ 2'b10 or SEQ 2'b11, hReady high, hWrite high) asserts regWrEn in the next cycle with regAddr equal to the captured hAddr and regWdata equal to the live hWdata. regByteEn bit k enables bits [8k+7:8k]: hSize 0 (byte) enables lane hAddr[1:0], hSize 1 (halfword) enables lanes 0-1 or 2-3 chosen by hAddr[1], and hSize 2 (word) enables all four lanes.
- R4: A read address phase asserts regRdEn in the next cycle, and during that data phase hRdata equals regRdata.
- R5: While a strobe is asserted and regReady is 0, hReadyOut is 0, the strobe stays asserted and regAddr keeps the captured address even if hAddr changes on the bus.
- R6: If regReady and regError are both 1 during a data phase, hReadyOut is 0 with hResp 0 in that cycle, then hResp is 1 with hReadyOut 0, then hResp is 1 with hReadyOut 1.
- R7: A transfer whose address is not a multiple of its size (for example hSize 1 with hAddr[0] set), or whose hSize exceeds 2, gets hResp 1 with hReadyOut 0 in the next cycle and hResp 1 with hReadyOut 1 in the cycle after, and asserts no strobe.
- R8: The cycle that completes one transfer with hReadyOut 1 also accepts the next address phase, so back-to-back transfers run with no idle cycle between their data phases.
- R9: An address phase with hReady low is not accepted: no strobe follows it.
- R10: hBurst, hProt and hMastLock have no effect on strobes, address, byte enables or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hSel | input | 1 | Subordinate select |
| hAddr | input | ADDR_W | Bus address |
| hTrans | input | 2 | Transfer type |
| hWrite | input | 1 | 1 for write, 0 for read |
| hSize | input | 3 | Transfer size, log2 of bytes |
| hBurst | input | 3 | Burst type (ignored) |
| hProt | input | 4 | Protection attributes (ignored) |
| hMastLock | input | 1 | Locked transfer flag (ignored) |
| hReady | input | 1 | Bus-level ready from the interconnect |
| hWdata | input | DATA_W | Write data, valid in the data phase |
| hRdata | output | DATA_W | Read data to the bus |
| hReadyOut | output | 1 | Data phase completion |
| hResp | output | 1 | 0 OKAY, 1 ERROR |
| regAddr | output | ADDR_W | Captured register address |
| regWrEn | output | 1 | Register write strobe |
| regRdEn | output | 1 | Register read strobe |
| regWdata | output | DATA_W | Register write data |
| regByteEn | output | DATA_W/8 | Byte lane enables |
| regRdata | input | DATA_W | Register read data |
| regReady | input | 1 | Register access complete |
| regError | input | 1 | Register access failed, valid with regReady |

## Verification
The bench aims at the cycle where capture could go wrong: during register wait states it moves hAddr, so a bridge that re-captured while stalled would show the new address on regAddr. It drives misaligned halfwords and an oversized size, which a bridge with a bad alignment check would pass on as writes, and it times the register error, which a bridge with a one-cycle or unregistered error would get out of step. Back-to-back transfers catch a bridge that inserts an idle cycle or drops the second address phase. An address phase offered while another subordinate holds hReady low catches a bridge that ignores hReady.

// File: rtl/ahb_reg_bridge_pkg.sv
package ahb_reg_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACCESS   = 2'd1,
    ST_ERR_HOLD = 2'd2,
    ST_ERR_DONE = 2'd3
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic wrStrobe;
    logic rdStrobe;
  } dpCtrl_t;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;

endpackage

// File: rtl/ahb_reg_bridge_dp.sv
module ahb_reg_bridge_dp
  import ahb_reg_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [2:0]        hSize,
  input  logic              hWrite,
  input  logic [DATA_W-1:0] hWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              accessBad,
  output logic              capWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [LANES-1:0]  regByteEn,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [DATA_W-1:0] hRdata
);

  logic [LANE_W-1:0] addrLow;
  logic [LANE_W-1:0] sizeMask;
  logic              sizeTooBig;
  logic              misaligned;
  logic [LANES-1:0]  byteEnNext;

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [LANES-1:0]  byteEnQ;

  assign addrLow = hAddr[LANE_W-1:0];

  // mask of address bits that must be zero for the requested size
  always_comb begin
    for (int i = 0; i < LANE_W; i++) begin
      sizeMask[i] = (32'(hSize) > i);
    end
  end

  assign sizeTooBig = (32'(hSize) > LANE_W);
  assign misaligned = |(addrLow & sizeMask);
  assign accessBad  = sizeTooBig || misaligned;

  // a lane is enabled when it falls in the same size-aligned block as the address
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign byteEnNext[k] = ~|((LANE_W'(k) ^ addrLow) & ~sizeMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      writeQ  <= 1'b0;
      byteEnQ <= '0;
    end else if (ctrl.capture) begin
      addrQ   <= hAddr;
      writeQ  <= hWrite;
      byteEnQ <= byteEnNext;
    end
  end

  assign capWrite  = writeQ;
  assign regAddr   = addrQ;
  assign regWrEn   = ctrl.wrStrobe;
  assign regRdEn   = ctrl.rdStrobe;
  assign regByteEn = (ctrl.wrStrobe || ctrl.rdStrobe) ? byteEnQ : '0;
  assign regWdata  = hWdata;
  assign hRdata    = ctrl.rdStrobe ? regRdata : '0;

  // R3
  strobeLanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |-> (regByteEn != '0));

  // R3
  oneStrobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

// File: rtl/ahb_reg_bridge_ctrl.sv
module ahb_reg_bridge_ctrl
  import ahb_reg_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hSel,
  input  logic [1:0] hTrans,
  input  logic       hReady,
  input  logic       accessBad,
  input  logic       capWrite,
  input  logic       regReady,
  input  logic       regError,
  output dpCtrl_t    dpCtrl,
  output logic       hReadyOut,
  output logic       hResp
);

  bridgeState_t state, stateNext;
  logic xferValid;
  logic addrPhase;
  logic accept;

  assign xferValid = hSel && (hTrans == TRANS_NONSEQ || hTrans == TRANS_SEQ);

  always_comb begin
    case (state)
      ST_ACCESS:   hReadyOut = regReady && !regError;
      ST_ERR_HOLD: hReadyOut = 1'b0;
      default:     hReadyOut = 1'b1;
    endcase
  end

  assign hResp     = (state == ST_ERR_HOLD) || (state == ST_ERR_DONE);
  assign addrPhase = hReadyOut && hReady;
  assign accept    = addrPhase && xferValid;

  always_comb begin
    stateNext = state;
    if (addrPhase) begin
      if (accept) stateNext = accessBad ? ST_ERR_HOLD : ST_ACCESS;
      else        stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_ACCESS:   if (regReady && regError) stateNext = ST_ERR_HOLD;
        ST_ERR_HOLD: stateNext = ST_ERR_DONE;
        default:     stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign dpCtrl.capture  = accept && !accessBad;
  assign dpCtrl.wrStrobe = (state == ST_ACCESS) && capWrite;
  assign dpCtrl.rdStrobe = (state == ST_ACCESS) && !capWrite;

  // R6
  errSecond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hResp && !hReadyOut) |=> (hResp && hReadyOut));

  // R6
  regErrTurn_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dpCtrl.wrStrobe || dpCtrl.rdStrobe) && regReady && regError)
      |=> (hResp && !hReadyOut));

  // R7
  badAccess_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && accessBad)
      |=> (hResp && !hReadyOut && !dpCtrl.wrStrobe && !dpCtrl.rdStrobe));

  // R2
  idleOkay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.wrStrobe && !dpCtrl.rdStrobe && !hResp) |-> hReadyOut);

endmodule

// File: rtl/ahb_reg_bridge.sv
module ahb_reg_bridge
  import ahb_reg_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSel,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [1:0]        hTrans,
  input  logic              hWrite,
  input  logic [2:0]        hSize,
  input  logic [2:0]        hBurst,
  input  logic [3:0]        hProt,
  input  logic              hMastLock,
  input  logic              hReady,
  input  logic [DATA_W-1:0] hWdata,
  output logic [DATA_W-1:0] hRdata,
  output logic              hReadyOut,
  output logic              hResp,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [DATA_W-1:0] regWdata,
  output logic [LANES-1:0]  regByteEn,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regReady,
  input  logic              regError
);

  dpCtrl_t dpCtrl;
  logic    accessBad;
  logic    capWrite;
  logic    unusedBusAttr;

  assign unusedBusAttr = ^{hBurst, hProt, hMastLock};

  ahb_reg_bridge_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hSel      (hSel),
    .hTrans    (hTrans),
    .hReady    (hReady),
    .accessBad (accessBad),
    .capWrite  (capWrite),
    .regReady  (regReady),
    .regError  (regError),
    .dpCtrl    (dpCtrl),
    .hReadyOut (hReadyOut),
    .hResp     (hResp)
  );

  ahb_reg_bridge_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .hAddr     (hAddr),
    .hSize     (hSize),
    .hWrite    (hWrite),
    .hWdata    (hWdata),
    .regRdata  (regRdata),
    .accessBad (accessBad),
    .capWrite  (capWrite),
    .regAddr   (regAddr),
    .regByteEn (regByteEn),
    .regWdata  (regWdata),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .hRdata    (hRdata)
  );

  // R5
  stallHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((regWrEn || regRdEn) && !regReady)
      |=> ($stable(regAddr) && (regWrEn || regRdEn)));

endmodule

// File: tb/ahb_reg_bridge_test.sv
module ahb_reg_bridge_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hSel = 1'b0;
  logic [ADDR_W-1:0] hAddr = '0;
  logic [1:0]        hTrans = 2'b00;
  logic              hWrite = 1'b0;
  logic [2:0]        hSize = 3'd0;
  logic [2:0]        hBurst = 3'd0;
  logic [3:0]        hProt = 4'd0;
  logic              hMastLock = 1'b0;
  logic              hReady;
  logic [DATA_W-1:0] hWdata = '0;
  logic [DATA_W-1:0] hRdata;
  logic              hReadyOut;
  logic              hResp;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic              regRdEn;
  logic [DATA_W-1:0] regWdata;
  logic [3:0]        regByteEn;
  logic [DATA_W-1:0] regRdata = 32'h5A3C_96E1;
  logic              regReady = 1'b1;
  logic              regError = 1'b0;
  logic              otherStall = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign hReady = hReadyOut & ~otherStall;

  ahb_reg_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hAddr(hAddr), .hTrans(hTrans),
    .hWrite(hWrite), .hSize(hSize), .hBurst(hBurst), .hProt(hProt),
    .hMastLock(hMastLock), .hReady(hReady), .hWdata(hWdata), .hRdata(hRdata),
    .hReadyOut(hReadyOut), .hResp(hResp), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .regByteEn(regByteEn),
    .regRdata(regRdata), .regReady(regReady), .regError(regError)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic busIdle();
    hSel = 1'b0; hTrans = 2'b00;
  endtask

  task automatic addrPhase(input logic wr, input logic [15:0] a, input logic [2:0] sz);
    hSel = 1'b1; hTrans = 2'b10; hWrite = wr; hAddr = a; hSize = sz;
  endtask

  task automatic quietCheck(input string tag);
    chk({tag, " wrEn"}, regWrEn, 0);
    chk({tag, " rdEn"}, regRdEn, 0);
    chk({tag, " ready"}, hReadyOut, 1);
    chk({tag, " resp"}, hResp, 0);
  endtask

  task automatic writeOnce(input string tag, input logic [15:0] a, input logic [2:0] sz,
                           input logic [31:0] d, input logic [3:0] be);
    step(); addrPhase(1'b1, a, sz);
    step(); busIdle(); hWdata = d;
    @(negedge clk);
    chk({tag, " wrEn"}, regWrEn, 1);
    chk({tag, " rdEn"}, regRdEn, 0);
    chk({tag, " addr"}, regAddr, a);
    chk({tag, " byteEn"}, regByteEn, be);
    chk({tag, " wdata"}, regWdata, d);
    chk({tag, " ready"}, hReadyOut, 1);
    chk({tag, " resp"}, hResp, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    quietCheck("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    quietCheck("R1 after reset");
  endtask

  task automatic testNoTransfer();
    step(); hSel = 1'b1; hTrans = 2'b00; hAddr = 16'h0040; hWrite = 1'b1; hSize = 3'd2;
    @(negedge clk); step(); hTrans = 2'b01;
    @(negedge clk); quietCheck("R2 after IDLE");
    step(); hSel = 1'b0; hTrans = 2'b10;
    @(negedge clk); quietCheck("R2 after BUSY");
    step(); busIdle();
    @(negedge clk); quietCheck("R2 after unselected");
  endtask

  task automatic testWrites();
    writeOnce("R3 word", 16'h0120, 3'd2, 32'hDEAD_BEEF, 4'b1111);
    writeOnce("R3 half hi", 16'h0132, 3'd1, 32'h1234_5678, 4'b1100);
    writeOnce("R3 half lo", 16'h0130, 3'd1, 32'h0000_ABCD, 4'b0011);
    writeOnce("R3 byte 1", 16'h0141, 3'd0, 32'h0000_7700, 4'b0010);
    writeOnce("R3 byte 3", 16'h0143, 3'd0, 32'h9900_0000, 4'b1000);
  endtask

  task automatic testRead();
    step(); addrPhase(1'b0, 16'h0204, 3'd2); regRdata = 32'hC0FF_EE01;
    step(); busIdle();
    @(negedge clk);
    chk("R4 rdEn", regRdEn, 1);
    chk("R4 wrEn", regWrEn, 0);
    chk("R4 addr", regAddr, 16'h0204);
    chk("R4 rdata", hRdata, 32'hC0FF_EE01);
    chk("R4 ready", hReadyOut, 1);
  endtask

  task automatic testWaitStates();
    step(); addrPhase(1'b0, 16'h0308, 3'd2); regRdata = 32'h0BAD_F00D;
    step(); hAddr = 16'h0F00; hTrans = 2'b10; hSel = 1'b1; regReady = 1'b0;
    for (int w = 0; w < 2; w++) begin
      @(negedge clk);
      chk("R5 stall ready", hReadyOut, 0);
      chk("R5 stall rdEn", regRdEn, 1);
      chk("R5 stall addr", regAddr, 16'h0308);
      step();
    end
    busIdle(); regReady = 1'b1;
    @(negedge clk);
    chk("R5 done ready", hReadyOut, 1);
    chk("R5 done rdata", hRdata, 32'h0BAD_F00D);
    chk("R5 done addr", regAddr, 16'h0308);
  endtask

  task automatic testRegError();
    step(); addrPhase(1'b1, 16'h0400, 3'd2);
    step(); busIdle(); hWdata = 32'h1111_2222; regError = 1'b1;
    @(negedge clk);
    chk("R6 first ready", hReadyOut, 0);
    chk("R6 first resp", hResp, 0);
    step(); regError = 1'b0;
    @(negedge clk);
    chk("R6 err1 resp", hResp, 1);
    chk("R6 err1 ready", hReadyOut, 0);
    chk("R6 err1 wrEn", regWrEn, 0);
    step();
    @(negedge clk);
    chk("R6 err2 resp", hResp, 1);
    chk("R6 err2 ready", hReadyOut, 1);
    step();
    @(negedge clk);
    quietCheck("R6 after");
  endtask

  task automatic badAccess(input string tag, input logic [15:0] a, input logic [2:0] sz);
    step(); addrPhase(1'b1, a, sz);
    step(); busIdle();
    @(negedge clk);
    chk({tag, " err1 resp"}, hResp, 1);
    chk({tag, " err1 ready"}, hReadyOut, 0);
    chk({tag, " err1 wrEn"}, regWrEn, 0);
    step();
    @(negedge clk);
    chk({tag, " err2 resp"}, hResp, 1);
    chk({tag, " err2 ready"}, hReadyOut, 1);
    chk({tag, " err2 wrEn"}, regWrEn, 0);
  endtask

  task automatic testMisaligned();
    badAccess("R7 half odd", 16'h0501, 3'd1);
    badAccess("R7 word off", 16'h0502, 3'd2);
    badAccess("R7 size 3", 16'h0508, 3'd3);
    step();
    @(negedge clk);
    quietCheck("R7 after");
  endtask

  task automatic testBackToBack();
    step(); addrPhase(1'b1, 16'h0600, 3'd2);
    step(); addrPhase(1'b0, 16'h0610, 3'd2); hWdata = 32'hAAAA_5555; regRdata = 32'h7E57_0001;
    @(negedge clk);
    chk("R8 first wrEn", regWrEn, 1);
    chk("R8 first addr", regAddr, 16'h0600);
    step(); busIdle();
    @(negedge clk);
    chk("R8 second rdEn", regRdEn, 1);
    chk("R8 second addr", regAddr, 16'h0610);
    chk("R8 second rdata", hRdata, 32'h7E57_0001);
  endtask

  task automatic testOtherStall();
    step(); addrPhase(1'b1, 16'h0700, 3'd2); otherStall = 1'b1;
    step(); busIdle(); otherStall = 1'b0;
    @(negedge clk);
    quietCheck("R9 stalled phase");
  endtask

  task automatic testIgnoredAttrs();
    hBurst = 3'b011; hProt = 4'hF; hMastLock = 1'b1;
    writeOnce("R10 attrs", 16'h0806, 3'd1, 32'h4321_0000, 4'b1100);
    hBurst = 3'b000; hProt = 4'h0; hMastLock = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    testReset();
    testNoTransfer();
    testWrites();
    testRead();
    testWaitStates();
    testRegError();
    testMisaligned();
    testBackToBack();
    testOtherStall();
    testIgnoredAttrs();
    step();
    summary();
  end

endmodule